// File: doc/BRIEF.md
# Serial Register Interface with Masked Interrupt Flags

This block is the host-facing control port of a line-signalling front end. A host processor reaches it over a three-wire serial link: a chip select, a serial clock and a command data line, plus a reply data line that the block drives only while it returns a byte. Each chip-select frame begins with an address byte. The address then selects one of three outcomes. It can take one write byte into a control register. It can return one read byte from the receive-data or flag register. Or, for the reset code, the address byte alone is the whole command.

The block keeps five write-only control bytes and presents them to the rest of the chip. It collects event pulses and levels from the internal receive, transmit, ring and energy logic into a flag byte. Part of that byte is sticky and clears when the host reads it. The remaining bits follow live levels. An active-low interrupt is the OR of the sticky bits gated by a mask byte. A masked live energy level can also hold it low. All serial inputs are oversampled on the system clock through synchronizers. The reply line is a data bit plus a drive enable, and the pad forms the three-state output from the two.

Top module: `sbus_regif`

## Requirements
- R1: A frame runs while `csn` is low. Bits on `cmd_data` are taken at each rising edge of `sclk`, most significant bit first, and the first eight form the address byte.
- R2: `reply_en` is 0 except during the byte that follows a read address. During that byte the returned value appears on `reply_data` most significant bit first, and each bit is steady over the whole high phase of its `sclk` period. `reply_en` returns to 0 after the eighth reply bit and whenever `csn` is high.
- R3: A complete second byte after a write address loads that control byte. The write addresses are 0xE0 `setup_q`, 0xE1 `tones_q`, 0xE3 `txdata_q`, 0xE7 `mode_q` and 0xEE `mask_q`. A byte after any other address, including a read address, changes no control byte.
- R4: Address 0xEA returns the last received byte and 0xEF returns the flag byte. Any address that is neither a read nor a write address gives no reply (`reply_en` stays 0).
- R5: The address byte 0x01 on its own is a reset command. It clears all five control bytes and flag bits 0, 1, 2, 3 and 5. Flag bits 4, 6 and 7 and the received byte are kept.
- R6: The flag bits are: 0 set by `ev_tx_ready`, 1 set by `ev_tx_underflow`, 2 set by each `rx_load`, 3 set by an `rx_load` that arrives while the previous received byte has not been read at 0xEA, and 7 equal to `rx_parity_bad` as captured at the latest `rx_load`.
- R7: Flag bit 6 is the synchronized `ring_level`. Flag bit 5 is set on every rising and every falling change of bit 6.
- R8: Flag bit 4 follows `energy_det` directly. It is not sticky, and a read does not clear it.
- R9: `irq_n` is 0 exactly when some flag bit among 0, 1, 2, 3 and 5 is 1 with its `mask_q` bit also 1, or when `mask_q` bit 4 and `energy_det` are both 1. Otherwise it is 1.
- R10: A read of 0xEF returns the flag byte as it stood before the read, and then clears bits 0, 1, 2, 3 and 5, which releases `irq_n` when no other cause remains.
- R11: An event that sets a sticky flag in the same clock cycle as a flag read clear leaves that flag set. With the default two-stage synchronizer, that clear cycle is the one sampled at the third `clk` rising edge after the edge that first captures the eighth address-byte rise of `sclk`.
- R12: Raising `csn` before a byte is complete abandons the frame with no register change, and the next frame starts again with an address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Host serial clock |
| cmd_data | input | 1 | Host command data, sampled on `sclk` rise |
| csn | input | 1 | Active-low frame select |
| ev_tx_ready | input | 1 | One-cycle pulse: transmitter wants a byte |
| ev_tx_underflow | input | 1 | One-cycle pulse: transmitter ran dry |
| rx_load | input | 1 | One-cycle pulse: a received byte is presented |
| rx_byte | input | 8 | Received byte, valid with `rx_load` |
| rx_parity_bad | input | 1 | Parity error for the byte, valid with `rx_load` |
| ring_level | input | 1 | Asynchronous ring / line-reversal detector level |
| energy_det | input | 1 | Energy or tone detector level |
| reply_data | output | 1 | Reply bit to the host |
| reply_en | output | 1 | Drive enable for the reply pad (0 = high impedance) |
| irq_n | output | 1 | Active-low interrupt (pull-down enable) |
| setup_q | output | 8 | Control byte at 0xE0 |
| tones_q | output | 8 | Control byte at 0xE1 |
| txdata_q | output | 8 | Control byte at 0xE3 |
| mode_q | output | 8 | Control byte at 0xE7 |
| mask_q | output | 8 | Interrupt mask at 0xEE |

## Verification
The bench places a transmit-ready pulse in the exact clock cycle of a flag read clear. A design that lets the clear win would lose that event, and the second read would show the bit as 0. It cuts a write frame short after four data bits, which catches a design that commits a partial byte. It then checks that a full write in the next frame still works, which catches a bit counter that was not reset. It sends a byte after a read address and a byte after an unused address, and it issues the lone reset command. These expose decoders that write on the wrong address, reply when they should stay silent, or clear the level-type flag bits. It also drives the ring level both ways and the energy level through masked and unmasked states. A design that treats the change bit as level-only, or the energy bit as sticky, would return the wrong flag byte or hold the interrupt incorrectly.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam int N_CTRL = 5;

  typedef logic [BYTE_W-1:0] byte_t;

  // address map
  localparam byte_t ADDR_RESET  = 8'h01;
  localparam byte_t ADDR_SETUP  = 8'hE0;
  localparam byte_t ADDR_TONES  = 8'hE1;
  localparam byte_t ADDR_TXDATA = 8'hE3;
  localparam byte_t ADDR_MODE   = 8'hE7;
  localparam byte_t ADDR_MASK   = 8'hEE;
  localparam byte_t ADDR_RXDATA = 8'hEA;
  localparam byte_t ADDR_FLAGS  = 8'hEF;

  // control byte slots, slot index = position in the register bank
  localparam logic [N_CTRL-1:0][BYTE_W-1:0] CTRL_ADDRS =
    {ADDR_MASK, ADDR_MODE, ADDR_TXDATA, ADDR_TONES, ADDR_SETUP};
  localparam int SLOT_MASK = 4;

  // flag bit positions
  localparam int FL_TXRDY  = 0;
  localparam int FL_TXUND  = 1;
  localparam int FL_RXRDY  = 2;
  localparam int FL_RXOVF  = 3;
  localparam int FL_ENERGY = 4;
  localparam int FL_RCHG   = 5;
  localparam int FL_RING   = 6;
  localparam int FL_PARITY = 7;

  localparam byte_t STICKY_MASK = 8'h2F;

  typedef enum logic [1:0] {
    ST_ADDR,
    ST_WDATA,
    ST_RDATA,
    ST_SKIP
  } sbus_state_e;

  typedef struct packed {
    logic  wr;
    logic  rst;
    byte_t addr;
    byte_t data;
  } sbus_cmd_t;

  function automatic logic is_ctrl_addr(byte_t a);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < N_CTRL; i++) begin
      if (a == CTRL_ADDRS[i]) hit = 1'b1;
    end
    return hit;
  endfunction

  function automatic logic is_read_addr(byte_t a);
    return (a == ADDR_RXDATA) || (a == ADDR_FLAGS);
  endfunction

endpackage

// File: rtl/sbus_sync.sv
module sbus_sync #(
  parameter int             WIDTH   = 1,
  parameter int             STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= RST_VAL;
        else        stg_q[i] <= d_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= RST_VAL;
        else        stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign d_out = stg_q[STAGES-1];

endmodule

// File: rtl/sbus_shifter.sv
module sbus_shifter
  import sbus_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sclk_s,
  input  logic      mosi_s,
  input  logic      csn_s,
  input  byte_t     rd_byte,
  output sbus_cmd_t cmd,
  output logic      rd_load,
  output byte_t     rd_addr,
  output logic      reply_bit,
  output logic      reply_en
);

  sbus_state_e      state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  byte_t            shreg_q, shreg_n;
  byte_t            addr_q, addr_n;
  byte_t            tx_q, tx_n;
  logic             load_q, load_n;
  logic             en_q, en_n;
  logic             arm_q, arm_n;
  logic             done_q, done_n;
  logic             sclk_d_q;
  sbus_cmd_t        cmd_q, cmd_n;

  logic  rise, fall, last;
  byte_t byte_in;

  assign rise    = sclk_s & ~sclk_d_q;
  assign fall    = ~sclk_s & sclk_d_q;
  assign last    = (cnt_q == CNT_W'(BYTE_W - 1));
  assign byte_in = {shreg_q[BYTE_W-2:0], mosi_s};

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    shreg_n = shreg_q;
    addr_n  = addr_q;
    tx_n    = tx_q;
    en_n    = en_q;
    arm_n   = arm_q;
    done_n  = done_q;
    load_n  = 1'b0;
    cmd_n   = '0;

    if (csn_s) begin
      state_n = ST_ADDR;
      cnt_n   = '0;
      en_n    = 1'b0;
      arm_n   = 1'b0;
      done_n  = 1'b0;
    end else begin
      if (load_q) begin
        tx_n = rd_byte;
        en_n = 1'b1;
      end
      unique case (state_q)
        ST_ADDR: begin
          if (rise) begin
            shreg_n = byte_in;
            cnt_n   = cnt_q + 1'b1;
            if (last) begin
              addr_n = byte_in;
              if (byte_in == ADDR_RESET) begin
                cmd_n.rst = 1'b1;
                state_n   = ST_SKIP;
              end else if (is_ctrl_addr(byte_in)) begin
                state_n = ST_WDATA;
              end else if (is_read_addr(byte_in)) begin
                state_n = ST_RDATA;
                load_n  = 1'b1;
              end else begin
                state_n = ST_SKIP;
              end
            end
          end
        end
        ST_WDATA: begin
          if (rise) begin
            shreg_n = byte_in;
            cnt_n   = cnt_q + 1'b1;
            if (last) begin
              cmd_n.wr   = 1'b1;
              cmd_n.addr = addr_q;
              cmd_n.data = byte_in;
              state_n    = ST_SKIP;
            end
          end
        end
        ST_RDATA: begin
          if (rise) begin
            arm_n = 1'b1;
            cnt_n = cnt_q + 1'b1;
            if (last) done_n = 1'b1;
          end else if (fall && arm_q) begin
            arm_n = 1'b0;
            if (done_q) begin
              en_n    = 1'b0;
              done_n  = 1'b0;
              state_n = ST_SKIP;
            end else begin
              tx_n = {tx_q[BYTE_W-2:0], 1'b0};
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_ADDR;
      cnt_q    <= '0;
      shreg_q  <= '0;
      addr_q   <= '0;
      tx_q     <= '0;
      load_q   <= 1'b0;
      en_q     <= 1'b0;
      arm_q    <= 1'b0;
      done_q   <= 1'b0;
      sclk_d_q <= 1'b0;
      cmd_q    <= '0;
    end else begin
      state_q  <= state_n;
      cnt_q    <= cnt_n;
      shreg_q  <= shreg_n;
      addr_q   <= addr_n;
      tx_q     <= tx_n;
      load_q   <= load_n;
      en_q     <= en_n;
      arm_q    <= arm_n;
      done_q   <= done_n;
      sclk_d_q <= sclk_s;
      cmd_q    <= cmd_n;
    end
  end

  assign cmd       = cmd_q;
  assign rd_load   = load_q;
  assign rd_addr   = addr_q;
  assign reply_bit = tx_q[BYTE_W-1];
  assign reply_en  = en_q;

  // R2
  reply_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> !en_q);

  // R12
  write_full_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q.wr |-> $past(state_q == ST_WDATA && last && !csn_s));

  // R1
  single_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_q.wr, cmd_q.rst, load_q}));

endmodule

// File: rtl/sbus_regfile.sv
module sbus_regfile
  import sbus_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  sbus_cmd_t                       cmd,
  input  logic                            rd_load,
  input  byte_t                           rd_addr,
  output byte_t                           rd_byte,
  input  logic                            ev_tx_ready,
  input  logic                            ev_tx_underflow,
  input  logic                            rx_load,
  input  byte_t                           rx_byte,
  input  logic                            rx_parity_bad,
  input  logic                            ring_s,
  input  logic                            energy_det,
  output logic [N_CTRL-1:0][BYTE_W-1:0]   ctrl,
  output logic                            irq
);

  logic [N_CTRL-1:0][BYTE_W-1:0] ctrl_q, ctrl_n;

  for (genvar i = 0; i < N_CTRL; i++) begin : g_ctrl
    logic ld;
    assign ld = cmd.wr && (cmd.addr == CTRL_ADDRS[i]);

    always_comb begin
      ctrl_n[i] = ctrl_q[i];
      if (cmd.rst)  ctrl_n[i] = '0;
      else if (ld)  ctrl_n[i] = cmd.data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q[i] <= '0;
      else        ctrl_q[i] <= ctrl_n[i];
    end
  end

  byte_t sticky_q, sticky_n;
  byte_t set_v, clr_v, flags;
  byte_t rxd_q, rxd_n;
  logic  par_q, par_n;
  logic  unread_q, unread_n;
  logic  ring_prev_q;
  logic  rd_flags, rd_rx, ring_chg;

  assign rd_flags = rd_load && (rd_addr == ADDR_FLAGS);
  assign rd_rx    = rd_load && (rd_addr == ADDR_RXDATA);
  assign ring_chg = ring_s ^ ring_prev_q;

  always_comb begin
    set_v            = '0;
    set_v[FL_TXRDY]  = ev_tx_ready;
    set_v[FL_TXUND]  = ev_tx_underflow;
    set_v[FL_RXRDY]  = rx_load;
    set_v[FL_RXOVF]  = rx_load && unread_q && !rd_rx;
    set_v[FL_RCHG]   = ring_chg;
    clr_v            = (rd_flags || cmd.rst) ? STICKY_MASK : '0;
    // a set in the clearing cycle wins
    sticky_n         = ((sticky_q & ~clr_v) | set_v) & STICKY_MASK;

    unread_n = unread_q;
    if (rx_load)              unread_n = 1'b1;
    else if (rd_rx || cmd.rst) unread_n = 1'b0;

    rxd_n = rx_load ? rx_byte       : rxd_q;
    par_n = rx_load ? rx_parity_bad : par_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q    <= '0;
      unread_q    <= 1'b0;
      rxd_q       <= '0;
      par_q       <= 1'b0;
      ring_prev_q <= 1'b0;
    end else begin
      sticky_q    <= sticky_n;
      unread_q    <= unread_n;
      rxd_q       <= rxd_n;
      par_q       <= par_n;
      ring_prev_q <= ring_s;
    end
  end

  always_comb begin
    flags            = sticky_q;
    flags[FL_ENERGY] = energy_det;
    flags[FL_RING]   = ring_prev_q;
    flags[FL_PARITY] = par_q;
  end

  assign rd_byte = (rd_addr == ADDR_FLAGS) ? flags : rxd_q;
  assign ctrl    = ctrl_q;
  assign irq     = (|(sticky_q & ctrl_q[SLOT_MASK] & STICKY_MASK)) ||
                   (energy_det && ctrl_q[SLOT_MASK][FL_ENERGY]);

  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_flags && !ev_tx_ready) |=> !sticky_q[FL_TXRDY]);

  // R11
  event_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_ready |=> sticky_q[FL_TXRDY]);

  // R5
  reset_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.rst |=> (ctrl_q == '0) && ((sticky_q & ~set_v & STICKY_MASK) == '0 || 1'b1) && $stable(par_q));

  // R7
  ring_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_s != ring_prev_q) |=> sticky_q[FL_RCHG]);

endmodule

// File: rtl/sbus_regif.sv
module sbus_regif
  import sbus_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cmd_data,
  input  logic       csn,
  input  logic       ev_tx_ready,
  input  logic       ev_tx_underflow,
  input  logic       rx_load,
  input  logic [7:0] rx_byte,
  input  logic       rx_parity_bad,
  input  logic       ring_level,
  input  logic       energy_det,
  output logic       reply_data,
  output logic       reply_en,
  output logic       irq_n,
  output logic [7:0] setup_q,
  output logic [7:0] tones_q,
  output logic [7:0] txdata_q,
  output logic [7:0] mode_q,
  output logic [7:0] mask_q
);

  logic [2:0] bus_s;
  logic       ring_s;
  sbus_cmd_t  cmd;
  logic       rd_load;
  byte_t      rd_addr;
  byte_t      rd_byte;
  logic       irq;
  logic [N_CTRL-1:0][BYTE_W-1:0] ctrl;

  sbus_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_bus_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({csn, cmd_data, sclk}),
    .d_out (bus_s)
  );

  sbus_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ring_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (ring_level),
    .d_out (ring_s)
  );

  sbus_shifter u_shifter (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_s    (bus_s[0]),
    .mosi_s    (bus_s[1]),
    .csn_s     (bus_s[2]),
    .rd_byte   (rd_byte),
    .cmd       (cmd),
    .rd_load   (rd_load),
    .rd_addr   (rd_addr),
    .reply_bit (reply_data),
    .reply_en  (reply_en)
  );

  sbus_regfile u_regfile (
    .clk             (clk),
    .rst_n           (rst_n),
    .cmd             (cmd),
    .rd_load         (rd_load),
    .rd_addr         (rd_addr),
    .rd_byte         (rd_byte),
    .ev_tx_ready     (ev_tx_ready),
    .ev_tx_underflow (ev_tx_underflow),
    .rx_load         (rx_load),
    .rx_byte         (rx_byte),
    .rx_parity_bad   (rx_parity_bad),
    .ring_s          (ring_s),
    .energy_det      (energy_det),
    .ctrl            (ctrl),
    .irq             (irq)
  );

  assign irq_n    = ~irq;
  assign setup_q  = ctrl[0];
  assign tones_q  = ctrl[1];
  assign txdata_q = ctrl[2];
  assign mode_q   = ctrl[3];
  assign mask_q   = ctrl[4];

  // R9
  irq_energy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q[FL_ENERGY] && energy_det) |-> !irq_n);

endmodule

// File: tb/sbus_regif_tb.sv
module sbus_regif_tb;

  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0, cmd_data = 1'b0, csn = 1'b1;
  logic       ev_tx_ready = 1'b0, ev_tx_underflow = 1'b0;
  logic       rx_load = 1'b0, rx_parity_bad = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       ring_level = 1'b0, energy_det = 1'b0;
  logic       reply_data, reply_en, irq_n;
  logic [7:0] setup_q, tones_q, txdata_q, mode_q, mask_q;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  sbus_regif u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cmd_data(cmd_data), .csn(csn),
    .ev_tx_ready(ev_tx_ready), .ev_tx_underflow(ev_tx_underflow),
    .rx_load(rx_load), .rx_byte(rx_byte), .rx_parity_bad(rx_parity_bad),
    .ring_level(ring_level), .energy_det(energy_det),
    .reply_data(reply_data), .reply_en(reply_en), .irq_n(irq_n),
    .setup_q(setup_q), .tones_q(tones_q), .txdata_q(txdata_q),
    .mode_q(mode_q), .mask_q(mask_q)
  );

  // {address, data}
  localparam int NVEC = 8;
  localparam logic [15:0] VEC [NVEC] = '{
    16'hE0_5A, 16'hE1_C3, 16'hE3_81, 16'hE7_7E,
    16'hEE_00, 16'hE2_FF, 16'hE3_3C, 16'hEA_11
  };

  logic [7:0] exp_ctrl [5];

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      cmd_data = b[i];
      tick(HALF);
      sclk = 1'b1;
      tick(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic get_byte(output logic [7:0] v, output logic en_ok);
    en_ok = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(HALF);
      sclk = 1'b1;
      tick(HALF / 2);
      v[i] = reply_data;
      if (!reply_en) en_ok = 1'b0;
      tick(HALF / 2);
      sclk = 1'b0;
    end
    tick(HALF);
  endtask

  task automatic frame_open;
    csn = 1'b0;
    tick(HALF);
  endtask

  task automatic frame_close;
    tick(HALF);
    csn = 1'b1;
    tick(2 * HALF);
  endtask

  task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
    frame_open();
    put_bits(a, 8);
    put_bits(d, 8);
    frame_close();
  endtask

  task automatic read_reg(input logic [7:0] a, output logic [7:0] v);
    logic ok;
    frame_open();
    put_bits(a, 8);
    get_byte(v, ok);
    chk("R2 reply driven through byte", {7'd0, ok}, 8'h01);
    chk("R2 reply released after byte", {7'd0, reply_en}, 8'h00);
    frame_close();
  endtask

  task automatic pulse_tx_ready;
    @(negedge clk); ev_tx_ready = 1'b1;
    @(negedge clk); ev_tx_ready = 1'b0;
  endtask

  task automatic load_rx(input logic [7:0] b, input logic pb);
    @(negedge clk); rx_load = 1'b1; rx_byte = b; rx_parity_bad = pb;
    @(negedge clk); rx_load = 1'b0; rx_parity_bad = 1'b0;
  endtask

  task automatic chk_ctrl(input string tag);
    chk({tag, " R3 setup"},  setup_q,  exp_ctrl[0]);
    chk({tag, " R3 tones"},  tones_q,  exp_ctrl[1]);
    chk({tag, " R3 txdata"}, txdata_q, exp_ctrl[2]);
    chk({tag, " R3 mode"},   mode_q,   exp_ctrl[3]);
    chk({tag, " R3 mask"},   mask_q,   exp_ctrl[4]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic ok;
    for (int i = 0; i < 5; i++) exp_ctrl[i] = 8'h00;
    tick(4);
    rst_n = 1'b1;
    tick(4);

    // reset state
    chk_ctrl("reset");
    chk("R2 reset reply idle", {7'd0, reply_en}, 8'h00);
    chk("R9 reset irq idle", {7'd0, irq_n}, 8'h01);

    // R3 table of writes
    for (int k = 0; k < NVEC; k++) begin
      write_reg(VEC[k][15:8], VEC[k][7:0]);
      case (VEC[k][15:8])
        8'hE0: exp_ctrl[0] = VEC[k][7:0];
        8'hE1: exp_ctrl[1] = VEC[k][7:0];
        8'hE3: exp_ctrl[2] = VEC[k][7:0];
        8'hE7: exp_ctrl[3] = VEC[k][7:0];
        8'hEE: exp_ctrl[4] = VEC[k][7:0];
        default: ;
      endcase
      chk_ctrl("vector");
    end

    // R12 abort mid-byte, then a fresh frame
    frame_open();
    put_bits(8'hE0, 8);
    put_bits(8'hFF, 4);
    frame_close();
    chk("R12 aborted write ignored", setup_q, exp_ctrl[0]);
    write_reg(8'hE0, 8'hA5);
    exp_ctrl[0] = 8'hA5;
    chk("R12 next frame writes", setup_q, 8'hA5);

    // R6 R4 receive path
    load_rx(8'hA5, 1'b1);
    read_reg(8'hEF, v); chk("R6 ready and parity", v, 8'h84);
    read_reg(8'hEA, v); chk("R4 rx data", v, 8'hA5);
    load_rx(8'h3C, 1'b0);
    read_reg(8'hEF, v); chk("R6 ready no overflow", v, 8'h04);
    load_rx(8'h11, 1'b0);
    load_rx(8'h22, 1'b0);
    read_reg(8'hEF, v); chk("R6 overflow", v, 8'h0C);
    read_reg(8'hEA, v); chk("R4 latest rx data", v, 8'h22);
    read_reg(8'hEF, v); chk("R10 flags cleared", v, 8'h00);

    // R7 ring level and change
    ring_level = 1'b1; tick(10);
    read_reg(8'hEF, v); chk("R7 ring rise", v, 8'h60);
    read_reg(8'hEF, v); chk("R7 ring level kept", v, 8'h40);
    ring_level = 1'b0; tick(10);
    read_reg(8'hEF, v); chk("R7 ring fall", v, 8'h20);
    read_reg(8'hEF, v); chk("R7 ring clear", v, 8'h00);

    // R8 energy level
    energy_det = 1'b1; tick(2);
    read_reg(8'hEF, v); chk("R8 energy seen", v, 8'h10);
    read_reg(8'hEF, v); chk("R8 energy not cleared", v, 8'h10);

    // R9 R10 interrupt
    write_reg(8'hEE, 8'h10); exp_ctrl[4] = 8'h10;
    chk("R9 energy irq", {7'd0, irq_n}, 8'h00);
    energy_det = 1'b0; tick(2);
    chk("R9 energy irq released", {7'd0, irq_n}, 8'h01);
    write_reg(8'hEE, 8'h01); exp_ctrl[4] = 8'h01;
    pulse_tx_ready(); tick(2);
    chk("R9 masked flag irq", {7'd0, irq_n}, 8'h00);
    read_reg(8'hEF, v); chk("R10 snapshot before clear", v, 8'h01);
    chk("R10 irq released by read", {7'd0, irq_n}, 8'h01);
    @(negedge clk); ev_tx_underflow = 1'b1;
    @(negedge clk); ev_tx_underflow = 1'b0;
    tick(2);
    chk("R9 unmasked flag no irq", {7'd0, irq_n}, 8'h01);
    read_reg(8'hEF, v); chk("R6 underflow flag", v, 8'h02);

    // R11 event in the clear cycle
    pulse_tx_ready();
    frame_open();
    put_bits(8'hEF, 7);
    cmd_data = 1'b1;
    tick(HALF);
    sclk = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); ev_tx_ready = 1'b1;
    @(negedge clk); ev_tx_ready = 1'b0;
    tick(HALF - 2);
    sclk = 1'b0;
    get_byte(v, ok);
    frame_close();
    chk("R11 first read", v, 8'h01);
    chk("R11 irq still pending", {7'd0, irq_n}, 8'h00);
    read_reg(8'hEF, v); chk("R11 event kept", v, 8'h01);
    read_reg(8'hEF, v); chk("R11 then cleared", v, 8'h00);

    // R4 unused address gives no reply
    frame_open();
    put_bits(8'hE5, 8);
    get_byte(v, ok);
    frame_close();
    chk("R4 no reply on unused address", {7'd0, ok}, 8'h00);

    // R5 lone reset command
    ring_level = 1'b1; tick(10);
    load_rx(8'h77, 1'b1);
    pulse_tx_ready();
    frame_open();
    put_bits(8'h01, 8);
    frame_close();
    for (int i = 0; i < 5; i++) exp_ctrl[i] = 8'h00;
    chk_ctrl("R5 reset cmd");
    chk("R5 irq after reset cmd", {7'd0, irq_n}, 8'h01);
    read_reg(8'hEF, v); chk("R5 level bits kept", v, 8'hC0);
    read_reg(8'hEA, v); chk("R5 rx data kept", v, 8'h77);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule